// File: doc/BRIEF.md
# Front-Panel Memory Examine and Deposit Engine

This block lets an operator look at memory and change it through a row of sixteen toggle switches while the processor is halted. It keeps its own current-address register. Examine commands load or step that register and read the addressed byte back. Deposit commands write the low switch byte at that address, or step the address first and then write. An 8-bit accumulator register can be loaded from the switches or shown on the data lamps. Separately, the upper switch byte answers processor input reads on one fixed I/O port, so the switches can be polled as sense inputs.

The block drives a simple synchronous memory port. Read data is valid one clock after the address is presented. A write-protect input tells the block that the block of memory now addressed must not change. Commands are single-cycle pulses. They are accepted only while the run controller holds panel-enable high and no earlier memory access is still in progress.

Top module: `panel_mem_engine`

## Requirements
- R1: After reset the address display, data display and accumulator are zero, and busy and write enable are low.
- R2: Examine loads all 16 switch bits into the address register. The byte stored at that address appears on the data display on the second rising edge after the edge that accepts the command. Busy is high for the two cycles in between.
- R3: Examine-next adds one to the address register, then reads that location and displays it with the same timing as examine.
- R4: Deposit writes switch bits 7..0 into the location on the address display with a single write-enable cycle. It then reads the location back, and the data display shows the stored byte on the third rising edge after acceptance.
- R5: Deposit-next adds one to the address register first, then behaves like deposit at the new address.
- R6: While the protect input is high, write enable stays low. A deposit then leaves memory unchanged, and the data display shows the old byte.
- R7: Accumulator-load copies switch bits 7..0 into the accumulator. Accumulator-display puts the accumulator on the data display on the next edge, without any memory access.
- R8: An input read on port 0xFF (377 octal) returns switch bits 15..8 on the I/O data output. A read of any other port, or no read, returns zero.
- R9: With panel-enable low, every command is ignored. The address, the accumulator, the displays and memory stay unchanged.
- R10: Incrementing address 0xFFFF gives 0x0000.
- R11: A command that arrives while busy is high is dropped and leaves no trace.
- R12: When more than one command pulses in the same cycle, only one is taken, in this priority: examine, examine-next, deposit, deposit-next, accumulator-load, accumulator-display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw | input | 16 | Address/data toggle switches |
| panel_en | input | 1 | High while the processor is stopped |
| cmd_exam | input | 1 | Examine pulse |
| cmd_exam_next | input | 1 | Examine-next pulse |
| cmd_dep | input | 1 | Deposit pulse |
| cmd_dep_next | input | 1 | Deposit-next pulse |
| cmd_acc_load | input | 1 | Accumulator-load pulse |
| cmd_acc_show | input | 1 | Accumulator-display pulse |
| blk_protect | input | 1 | The addressed memory block is write-protected |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| io_rd | input | 1 | Processor input read strobe |
| io_port | input | 8 | Processor I/O port number |
| io_data | output | 8 | Sense data returned to the processor |
| addr_disp | output | 16 | Address display |
| data_disp | output | 8 | Data display |
| busy | output | 1 | Memory access in progress |

## Verification
The bench goes after the read latency first. A design that captured read data one edge early would show the previous address's byte. It then stops at the top of the address space: a design that failed to wrap, or that stepped only the low byte, would display the wrong location after examine-next from 0xFFFF. Deposits made while protected must leave memory intact. A design that let the write through would show the new byte and change the memory model. Finally, a command issued during busy, and any command issued with panel-enable low, must not move the address. A design that queued or accepted such commands would end at a different address or raise busy.

// File: rtl/panel_mem_engine.sv
module panel_mem_engine #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [7:0] SENSE_PORT = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sw,
  input  logic          panel_en,
  input  logic          cmd_exam,
  input  logic          cmd_exam_next,
  input  logic          cmd_dep,
  input  logic          cmd_dep_next,
  input  logic          cmd_acc_load,
  input  logic          cmd_acc_show,
  input  logic          blk_protect,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  input  logic          io_rd,
  input  logic [7:0]    io_port,
  output logic [DW-1:0] io_data,
  output logic [AW-1:0] addr_disp,
  output logic [DW-1:0] data_disp,
  output logic          busy
);
  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_CAP} st_t;
  st_t st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, data_q, acc_q;

  wire take = panel_en && (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0;
      wdata_q <= '0;
      data_q <= '0;
      acc_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          if (cmd_exam) begin
            addr_q <= sw;
            st <= S_RD;
          end else if (cmd_exam_next) begin
            addr_q <= addr_q + 1'b1;
            st <= S_RD;
          end else if (cmd_dep) begin
            wdata_q <= sw[DW-1:0];
            st <= S_WR;
          end else if (cmd_dep_next) begin
            addr_q <= addr_q + 1'b1;
            wdata_q <= sw[DW-1:0];
            st <= S_WR;
          end else if (cmd_acc_load) begin
            acc_q <= sw[DW-1:0];
          end else if (cmd_acc_show) begin
            data_q <= acc_q;
          end
        end
        S_WR: st <= S_RD;
        S_RD: st <= S_CAP;
        default: begin
          data_q <= mem_rdata;
          st <= S_IDLE;
        end
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = (st == S_WR) && !blk_protect;
  assign addr_disp = addr_q;
  assign data_disp = data_q;
  assign busy      = (st != S_IDLE);
  assign io_data   = (io_rd && io_port == SENSE_PORT) ? sw[AW-1:AW-DW] : '0;

  assert_no_write_protected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_protect |-> !mem_we);
  assert_write_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  assert_drop_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_disp));
  assert_ignore_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!panel_en && !busy) |=> ($stable(addr_disp) && !busy));
  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_en && !busy && !cmd_exam && cmd_exam_next && addr_disp == '1) |=> addr_disp == '0);
  assert_exam_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_en && !busy && cmd_exam) |=> (busy && addr_disp == $past(sw)));
endmodule

// File: tb/tb_panel_mem_engine.sv
module tb_panel_mem_engine;
  logic clk = 0, rst_n = 0;
  logic [15:0] sw = 0;
  logic panel_en = 1, blk_protect = 0, io_rd = 0;
  logic cmd_exam = 0, cmd_exam_next = 0, cmd_dep = 0, cmd_dep_next = 0;
  logic cmd_acc_load = 0, cmd_acc_show = 0;
  logic [7:0] io_port = 0, mem_rdata, mem_wdata, io_data, data_disp;
  logic [15:0] mem_addr, addr_disp;
  logic mem_we, busy;
  int checks = 0, errors = 0, wr_cnt = 0;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] exp_addr = 0;
  logic [7:0] exp_acc = 0;
  logic [23:0] q_exp[$];
  string q_tag[$];
  logic prev_busy = 0;

  always #5 clk = ~clk;

  panel_mem_engine dut (.clk, .rst_n, .sw, .panel_en, .cmd_exam, .cmd_exam_next,
    .cmd_dep, .cmd_dep_next, .cmd_acc_load, .cmd_acc_show, .blk_protect,
    .mem_addr, .mem_wdata, .mem_we, .mem_rdata, .io_rd, .io_port, .io_data,
    .addr_disp, .data_disp, .busy);

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i * 7 + 3);
    exp_mem[i] = 8'(i * 7 + 3);
  end

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (prev_busy && !busy) begin
      if (q_exp.size() == 0) check("R11 unexpected completion", 1, 0);
      else begin
        logic [23:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, {addr_disp, data_disp}, e);
      end
    end
    prev_busy <= busy;
  end

  task automatic pulse(input int k);
    @(negedge clk);
    case (k)
      0: cmd_exam = 1;
      1: cmd_exam_next = 1;
      2: cmd_dep = 1;
      3: cmd_dep_next = 1;
      4: cmd_acc_load = 1;
      default: cmd_acc_show = 1;
    endcase
    @(negedge clk);
    {cmd_exam, cmd_exam_next, cmd_dep, cmd_dep_next, cmd_acc_load, cmd_acc_show} = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_cmd(input int k, input logic [15:0] s, input string tag);
    @(negedge clk);
    sw = s;
    case (k)
      0: exp_addr = s;
      1: exp_addr = exp_addr + 1;
      3: exp_addr = exp_addr + 1;
      default: ;
    endcase
    if ((k == 2 || k == 3) && !blk_protect) exp_mem[exp_addr[7:0]] = s[7:0];
    q_exp.push_back({exp_addr, exp_mem[exp_addr[7:0]]});
    q_tag.push_back(tag);
    pulse(k);
    wait_idle();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset addr", addr_disp, 0);
    check("R1 reset data", data_disp, 0);
    check("R1 reset busy/we", {busy, mem_we}, 0);

    // R2 latency: busy for two cycles, then data
    @(negedge clk);
    sw = 16'h0012;
    exp_addr = 16'h0012;
    pulse(0);
    check("R2 busy during read", busy, 1);
    @(negedge clk);
    check("R2 still busy", busy, 1);
    q_exp.push_back({exp_addr, exp_mem[8'h12]});
    q_tag.push_back("R2 examine");
    wait_idle();

    do_cmd(0, 16'h3406, "R2 examine 3406");
    do_cmd(1, 16'h0000, "R3 examine-next");
    do_cmd(1, 16'h0000, "R3 examine-next again");
    do_cmd(0, 16'h0020, "R2 examine 0020");
    do_cmd(2, 16'h00FF, "R4 deposit");
    check("R4 memory written", mem[8'h20], 8'hFF);
    do_cmd(3, 16'h005A, "R5 deposit-next");
    check("R5 memory at next", mem[8'h21], 8'h5A);
    do_cmd(0, 16'h0020, "R4 re-examine");

    blk_protect = 1;
    w0 = wr_cnt;
    do_cmd(2, 16'h0011, "R6 protected deposit");
    do_cmd(3, 16'h0022, "R6 protected deposit-next");
    check("R6 no write pulses", wr_cnt - w0, 0);
    blk_protect = 0;

    do_cmd(0, 16'hFFFF, "R10 examine top");
    do_cmd(1, 16'h0000, "R10 wrap to zero");
    check("R10 address zero", addr_disp, 0);

    @(negedge clk);
    sw = 16'h00C3;
    exp_acc = 8'hC3;
    pulse(4);
    pulse(5);
    @(negedge clk);
    check("R7 accumulator display", data_disp, exp_acc);
    check("R7 no busy", busy, 0);

    sw = 16'hA53C;
    io_rd = 1;
    io_port = 8'hFF;
    #1 check("R8 sense port", io_data, 8'hA5);
    io_port = 8'hFE;
    #1 check("R8 other port", io_data, 0);
    io_rd = 0;
    io_port = 8'hFF;
    #1 check("R8 no read", io_data, 0);

    panel_en = 0;
    sw = 16'h0077;
    pulse(0);
    pulse(2);
    pulse(4);
    pulse(5);
    repeat (3) @(negedge clk);
    check("R9 addr unchanged", addr_disp, exp_addr);
    check("R9 data unchanged", data_disp, exp_acc);
    check("R9 memory unchanged", mem[8'h00], exp_mem[8'h00]);
    panel_en = 1;
    pulse(5);
    @(negedge clk);
    check("R9 accumulator unchanged", data_disp, exp_acc);

    // R11: second command during busy is dropped
    @(negedge clk);
    sw = 16'h0040;
    exp_addr = 16'h0040;
    q_exp.push_back({exp_addr, exp_mem[8'h40]});
    q_tag.push_back("R11 drop during busy");
    cmd_exam = 1;
    @(negedge clk);
    cmd_exam = 0;
    cmd_dep_next = 1;
    @(negedge clk);
    cmd_dep_next = 0;
    wait_idle();
    check("R11 memory untouched", mem[8'h41], exp_mem[8'h41]);

    // R12: examine beats deposit in the same cycle
    @(negedge clk);
    sw = 16'h0050;
    exp_addr = 16'h0050;
    q_exp.push_back({exp_addr, exp_mem[8'h50]});
    q_tag.push_back("R12 priority");
    cmd_exam = 1;
    cmd_dep = 1;
    @(negedge clk);
    {cmd_exam, cmd_dep} = '0;
    wait_idle();
    check("R12 no write", mem[8'h50], exp_mem[8'h50]);

    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", q_exp.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule